// File: doc/BRIEF.md
# Postfix Expression Evaluator

This block evaluates an expression that has already been put into postfix (reverse Polish) order. A producer feeds it one token at a time over a valid/ready handshake. Each token is either a signed value or an operator. Values go onto an internal result stack. Each operator takes the two most recent values and combines them with add, subtract, bitwise AND or bitwise OR. It then puts the result back on the stack.

An end token closes the expression. If exactly one value is left and no fault was seen, the block presents that value on a registered result port. It raises a one-cycle done strobe and a separate negative flag. Values are sign-magnitude. The result stack is a plain memory that allows one access per cycle, so an operator takes three cycles from acceptance to write-back. During that time the block holds off the producer.

Malformed streams raise a sticky error flag and suppress the done strobe. Such streams include an operator with too few values, an end token that leaves the wrong number of values, a push onto a full stack, and an unknown operator code. A magnitude carry out of the top bit raises a sticky overflow flag.

Top module: `rpn_eval`

## Requirements
- R1: A token with `tok_is_op`=0 is a value. A token with `tok_is_op`=1 is an operator whose code is in `tok_data[4:0]`: 00000 add, 00001 subtract, 00010 AND, 00011 OR, 11111 end. Any other operator code sets the error flag and leaves the stack untouched.
- R2: A value token is accepted in one cycle and pushed with all `VAL_W` bits as given. `tok_ready` stays high in the next cycle.
- R3: For an operator accepted with at least two values stored, the most recent value is the right operand and the one below it is the left operand. The block replaces both with left op right. `tok_ready` is low for exactly the two cycles after acceptance. The stack is never read and written in the same cycle.
- R4: Add and subtract use sign-magnitude rules, where subtract flips the sign of the right operand first. With equal signs the magnitudes are added and the common sign is kept. With different signs the smaller magnitude is taken from the larger and the sign of the larger is kept. A zero result is positive.
- R5: AND and OR apply the operation bitwise to the two magnitudes, and separately to the two sign bits.
- R6: An end token accepted with exactly one value stored and no error pending updates `res_value` and pulses `res_valid` for one cycle, two clock edges after acceptance. `res_neg` equals bit `VAL_W-1` of the result.
- R7: An arithmetic operator accepted with fewer than two values stored sets the error flag and does not change the stack.
- R8: An end token accepted with a stored-value count other than one sets the error flag. While the error flag is set, an end token produces no `res_valid`.
- R9: A value token accepted while `DEPTH` values are stored sets the error flag and is not stored.
- R10: An add or subtract whose magnitude sum carries out of bit `VAL_W-2` sets the overflow flag. The magnitude kept is truncated to its low `VAL_W-1` bits. Overflow alone does not suppress `res_valid`.
- R11: Every end token empties the stack. The error and overflow flags keep their value until the next token is accepted after an end token. They are cleared when that token is accepted, before it takes effect.
- R12: After reset `tok_ready` is 1 and `res_valid`, `res_value`, `res_neg`, `err_flag` and `ovf_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tok_valid | input | 1 | Token present on the token inputs |
| tok_ready | output | 1 | Block can take a token this cycle |
| tok_is_op | input | 1 | Token tag: 0 value, 1 operator |
| tok_data | input | VAL_W | Sign-magnitude value, or operator code in bits 4:0 |
| res_valid | output | 1 | One-cycle strobe: `res_value` holds a new result |
| res_value | output | VAL_W | Last result, sign in the top bit |
| res_neg | output | 1 | Sign of the last result |
| err_flag | output | 1 | Sticky malformed-stream flag |
| ovf_flag | output | 1 | Sticky magnitude-overflow flag |

## Verification
The hardest case to reach from the ports is a magnitude overflow. Producers normally send 4-bit magnitudes, and without a duplicate operator no short expression of such values can carry out of 16 bits. The stimulus therefore drives a value token with a full 16-bit magnitude, which the block stores unchanged, and adds a small value to it. Persistence of the sticky flags is checked by watching them stay set across idle cycles and clear on the first token of the next expression. The full-stack case is reached by pushing `DEPTH` values and then one more.

// File: rtl/rpn_pkg.sv
package rpn_pkg;

  localparam int OPC_W = 5;

  localparam logic [OPC_W-1:0] OPC_ADD = 5'b00000;
  localparam logic [OPC_W-1:0] OPC_SUB = 5'b00001;
  localparam logic [OPC_W-1:0] OPC_AND = 5'b00010;
  localparam logic [OPC_W-1:0] OPC_OR  = 5'b00011;
  localparam logic [OPC_W-1:0] OPC_END = 5'b11111;

  typedef enum logic [1:0] {
    S_IDLE,
    S_POPL,
    S_PUSH,
    S_FIN
  } eval_state_e;

endpackage

// File: rtl/rpn_stack.sv
// Result stack storage: one synchronous write port and one registered read
// port, written so that a block RAM can be inferred.
module rpn_stack #(
  parameter int W     = 17,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    if (re) begin
      rdata <= mem[raddr];
    end
  end

endmodule

// File: rtl/rpn_alu.sv
// Sign-magnitude add/subtract and bitwise AND/OR, purely combinational.
module rpn_alu
  import rpn_pkg::*;
#(
  parameter int W = 17
) (
  input  logic [W-1:0]     lhs,
  input  logic [W-1:0]     rhs,
  input  logic [OPC_W-1:0] op,
  output logic [W-1:0]     res,
  output logic             ovf
);

  localparam int MW = W - 1;

  logic          sa, sb, sg;
  logic [MW-1:0] ma, mb, mag;
  logic [MW:0]   sum;

  always_comb begin
    sa  = lhs[W-1];
    ma  = lhs[MW-1:0];
    mb  = rhs[MW-1:0];
    sb  = rhs[W-1] ^ (op == OPC_SUB);
    sum = {1'b0, ma} + {1'b0, mb};
    mag = '0;
    sg  = 1'b0;
    ovf = 1'b0;
    case (op)
      OPC_ADD, OPC_SUB: begin
        if (sa == sb) begin
          mag = sum[MW-1:0];
          sg  = sa;
          ovf = sum[MW];
        end else if (ma >= mb) begin
          mag = ma - mb;
          sg  = sa;
        end else begin
          mag = mb - ma;
          sg  = sb;
        end
        if (mag == '0) begin
          sg = 1'b0;
        end
      end
      OPC_AND: begin
        mag = ma & mb;
        sg  = sa & sb;
      end
      OPC_OR: begin
        mag = ma | mb;
        sg  = sa | sb;
      end
      default: begin
        mag = '0;
        sg  = 1'b0;
      end
    endcase
    res = {sg, mag};
  end

endmodule

// File: rtl/rpn_eval.sv
// Postfix evaluator: token intake, stack sequencing and result registers.
module rpn_eval
  import rpn_pkg::*;
#(
  parameter int VAL_W = 17,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tok_valid,
  output logic             tok_ready,
  input  logic             tok_is_op,
  input  logic [VAL_W-1:0] tok_data,
  output logic             res_valid,
  output logic [VAL_W-1:0] res_value,
  output logic             res_neg,
  output logic             err_flag,
  output logic             ovf_flag
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [CW-1:0] ONE  = CW'(1);
  localparam logic [CW-1:0] TWO  = CW'(2);

  eval_state_e      state_q, state_d;
  logic [CW-1:0]    depth_q, depth_d;
  logic [OPC_W-1:0] op_q, op_d;
  logic [VAL_W-1:0] rhs_q, rhs_d;
  logic [VAL_W-1:0] res_q, res_d;
  logic             neg_q, neg_d;
  logic             done_q, done_d;
  logic             err_q, err_d;
  logic             ovf_q, ovf_d;
  logic             fresh_q, fresh_d;

  logic             st_we, st_re;
  logic [AW-1:0]    st_waddr, st_raddr;
  logic [VAL_W-1:0] st_wdata, st_rdata;
  logic [VAL_W-1:0] alu_res;
  logic             alu_ovf;

  logic [OPC_W-1:0] code;
  logic             code_arith;

  assign code       = tok_data[OPC_W-1:0];
  assign code_arith = (code == OPC_ADD) || (code == OPC_SUB) ||
                      (code == OPC_AND) || (code == OPC_OR);

  rpn_stack #(
    .W     (VAL_W),
    .DEPTH (DEPTH)
  ) u_stack (
    .clk   (clk),
    .we    (st_we),
    .waddr (st_waddr),
    .wdata (st_wdata),
    .re    (st_re),
    .raddr (st_raddr),
    .rdata (st_rdata)
  );

  rpn_alu #(
    .W (VAL_W)
  ) u_alu (
    .lhs (st_rdata),
    .rhs (rhs_q),
    .op  (op_q),
    .res (alu_res),
    .ovf (alu_ovf)
  );

  always_comb begin
    state_d  = state_q;
    depth_d  = depth_q;
    op_d     = op_q;
    rhs_d    = rhs_q;
    res_d    = res_q;
    neg_d    = neg_q;
    done_d   = 1'b0;
    err_d    = err_q;
    ovf_d    = ovf_q;
    fresh_d  = fresh_q;
    st_we    = 1'b0;
    st_re    = 1'b0;
    st_waddr = '0;
    st_raddr = '0;
    st_wdata = tok_data;
    case (state_q)
      S_IDLE: begin
        if (tok_valid) begin
          if (fresh_q) begin
            err_d   = 1'b0;
            ovf_d   = 1'b0;
            fresh_d = 1'b0;
          end
          if (!tok_is_op) begin
            if (depth_q == FULL) begin
              err_d = 1'b1;
            end else begin
              st_we    = 1'b1;
              st_waddr = AW'(depth_q);
              depth_d  = depth_q + ONE;
            end
          end else if (code_arith) begin
            if (depth_q < TWO) begin
              err_d = 1'b1;
            end else begin
              st_re    = 1'b1;
              st_raddr = AW'(depth_q - ONE);
              op_d     = code;
              state_d  = S_POPL;
            end
          end else if (code == OPC_END) begin
            depth_d = '0;
            fresh_d = 1'b1;
            if (depth_q != ONE) begin
              err_d = 1'b1;
            end else if (!err_d) begin
              st_re    = 1'b1;
              st_raddr = '0;
              state_d  = S_FIN;
            end
          end else begin
            err_d = 1'b1;
          end
        end
      end
      S_POPL: begin
        rhs_d    = st_rdata;
        st_re    = 1'b1;
        st_raddr = AW'(depth_q - TWO);
        state_d  = S_PUSH;
      end
      S_PUSH: begin
        st_we    = 1'b1;
        st_waddr = AW'(depth_q - TWO);
        st_wdata = alu_res;
        depth_d  = depth_q - ONE;
        ovf_d    = ovf_q | alu_ovf;
        state_d  = S_IDLE;
      end
      S_FIN: begin
        res_d   = st_rdata;
        neg_d   = st_rdata[VAL_W-1];
        done_d  = 1'b1;
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      depth_q <= '0;
      op_q    <= '0;
      rhs_q   <= '0;
      res_q   <= '0;
      neg_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      ovf_q   <= 1'b0;
      fresh_q <= 1'b0;
    end else begin
      state_q <= state_d;
      depth_q <= depth_d;
      op_q    <= op_d;
      rhs_q   <= rhs_d;
      res_q   <= res_d;
      neg_q   <= neg_d;
      done_q  <= done_d;
      err_q   <= err_d;
      ovf_q   <= ovf_d;
      fresh_q <= fresh_d;
    end
  end

  assign tok_ready = (state_q == S_IDLE);
  assign res_valid = done_q;
  assign res_value = res_q;
  assign res_neg   = neg_q;
  assign err_flag  = err_q;
  assign ovf_flag  = ovf_q;

endmodule

// File: rtl/rpn_eval_chk.sv
module rpn_eval_chk #(
  parameter int VAL_W = 17,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             tok_valid,
  input logic             tok_ready,
  input logic             tok_is_op,
  input logic [4:0]       tok_code,
  input logic             res_valid,
  input logic [VAL_W-1:0] res_value,
  input logic             res_neg,
  input logic             err_flag,
  input logic             st_we,
  input logic             st_re,
  input logic [CW-1:0]    depth
);

  logic take, arith;
  assign take  = tok_valid && tok_ready;
  assign arith = tok_is_op && (tok_code[4:2] == 3'b000);

  AST_ONE_STACK_ACCESS: assert property (@(posedge clk) disable iff (rst)
    !(st_we && st_re)); // R3

  AST_OP_STALL: assert property (@(posedge clk) disable iff (rst)
    (take && arith && depth >= CW'(2)) |=> !tok_ready ##1 !tok_ready ##1 tok_ready); // R3

  AST_VALUE_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    (take && !tok_is_op) |=> tok_ready); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid); // R6

  AST_NEG_FOLLOWS_SIGN: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_neg == res_value[VAL_W-1])); // R6

  AST_UNDERFLOW_ERR: assert property (@(posedge clk) disable iff (rst)
    (take && arith && depth < CW'(2)) |=> (err_flag && tok_ready)); // R7

  AST_NO_DONE_WITH_ERR: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> !err_flag); // R8

  AST_DEPTH_LIMIT: assert property (@(posedge clk) disable iff (rst)
    depth <= CW'(DEPTH)); // R9

  AST_FULL_PUSH_ERR: assert property (@(posedge clk) disable iff (rst)
    (take && !tok_is_op && depth == CW'(DEPTH)) |=> (err_flag && depth == CW'(DEPTH))); // R9

endmodule

bind rpn_eval rpn_eval_chk #(
  .VAL_W (VAL_W),
  .DEPTH (DEPTH)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tok_valid (tok_valid),
  .tok_ready (tok_ready),
  .tok_is_op (tok_is_op),
  .tok_code  (tok_data[4:0]),
  .res_valid (res_valid),
  .res_value (res_value),
  .res_neg   (res_neg),
  .err_flag  (err_flag),
  .st_we     (st_we),
  .st_re     (st_re),
  .depth     (depth_q)
);

// File: tb/rpn_eval_bench.sv
module rpn_eval_bench;

  localparam int CLK_PERIOD = 10;
  localparam int VAL_W      = 17;
  localparam int DEPTH      = 16;
  localparam int MAXT       = 12;
  localparam int NVEC       = 19;

  // token = {tag, 17-bit payload}
  localparam logic [17:0] Z     = 18'h00000;
  localparam logic [17:0] T_ADD = 18'h20000;
  localparam logic [17:0] T_SUB = 18'h20001;
  localparam logic [17:0] T_AND = 18'h20002;
  localparam logic [17:0] T_OR  = 18'h20003;
  localparam logic [17:0] T_END = 18'h2001F;
  localparam logic [17:0] T_BAD = 18'h20007;

  function automatic logic [17:0] opd(input logic neg, input logic [15:0] mag);
    return {1'b0, neg, mag};
  endfunction

  typedef struct packed {
    logic [3:0]             req;
    logic [3:0]             ntk;
    logic [0:MAXT-1][17:0]  tk;
    logic [16:0]            exp;
    logic                   exp_err;
    logic                   exp_ovf;
  } vec_t;

  localparam vec_t VEC [NVEC] = '{
    // R5: 3 AND 4 = 0
    '{4'd5, 4'd4, '{opd(0,3), opd(0,4), T_AND, T_END, Z, Z, Z, Z, Z, Z, Z, Z}, 17'h00000, 1'b0, 1'b0},
    // R5: 5 AND 6 = 4
    '{4'd5, 4'd4, '{opd(0,5), opd(0,6), T_AND, T_END, Z, Z, Z, Z, Z, Z, Z, Z}, 17'h00004, 1'b0, 1'b0},
    // R4: 3 + 4 - 5 = 2
    '{4'd4, 4'd6, '{opd(0,3), opd(0,4), T_ADD, opd(0,5), T_SUB, T_END, Z, Z, Z, Z, Z, Z}, 17'h00002, 1'b0, 1'b0},
    // R4: 2 - 9 = -7
    '{4'd4, 4'd4, '{opd(0,2), opd(0,9), T_SUB, T_END, Z, Z, Z, Z, Z, Z, Z, Z}, 17'h10007, 1'b0, 1'b0},
    // R4: -3 + -4 = -7
    '{4'd4, 4'd4, '{opd(1,3), opd(1,4), T_ADD, T_END, Z, Z, Z, Z, Z, Z, Z, Z}, 17'h10007, 1'b0, 1'b0},
    // R4: 5 - 5 = +0
    '{4'd4, 4'd4, '{opd(0,5), opd(0,5), T_SUB, T_END, Z, Z, Z, Z, Z, Z, Z, Z}, 17'h00000, 1'b0, 1'b0},
    // R4: -5 + 5 = +0
    '{4'd4, 4'd4, '{opd(1,5), opd(0,5), T_ADD, T_END, Z, Z, Z, Z, Z, Z, Z, Z}, 17'h00000, 1'b0, 1'b0},
    // R5: -6 OR 3 -> sign 1, mag 7
    '{4'd5, 4'd4, '{opd(1,6), opd(0,3), T_OR, T_END, Z, Z, Z, Z, Z, Z, Z, Z}, 17'h10007, 1'b0, 1'b0},
    // R5: -6 AND -3 -> sign 1, mag 2
    '{4'd5, 4'd4, '{opd(1,6), opd(1,3), T_AND, T_END, Z, Z, Z, Z, Z, Z, Z, Z}, 17'h10002, 1'b0, 1'b0},
    // R3: (4+5) AND (6+(7 OR 1)) = 9
    '{4'd3, 4'd10, '{opd(0,4), opd(0,5), T_ADD, opd(0,6), opd(0,7), opd(0,1), T_OR, T_ADD, T_AND, T_END, Z, Z}, 17'h00009, 1'b0, 1'b0},
    // R3: operand order, 1 - (2 - 3) = 2
    '{4'd3, 4'd6, '{opd(0,1), opd(0,2), opd(0,3), T_SUB, T_SUB, T_END, Z, Z, Z, Z, Z, Z}, 17'h00002, 1'b0, 1'b0},
    // R4: -7 - 9 = -16
    '{4'd4, 4'd4, '{opd(1,7), opd(0,9), T_SUB, T_END, Z, Z, Z, Z, Z, Z, Z, Z}, 17'h10010, 1'b0, 1'b0},
    // R10: FFFF + 2 -> carry out, truncated to 1
    '{4'd10, 4'd4, '{opd(0,16'hFFFF), opd(0,2), T_ADD, T_END, Z, Z, Z, Z, Z, Z, Z, Z}, 17'h00001, 1'b0, 1'b1},
    // R7: operator with one value
    '{4'd7, 4'd3, '{opd(0,5), T_ADD, T_END, Z, Z, Z, Z, Z, Z, Z, Z, Z}, 17'h00000, 1'b1, 1'b0},
    // R8: end with two values
    '{4'd8, 4'd3, '{opd(0,1), opd(0,2), T_END, Z, Z, Z, Z, Z, Z, Z, Z, Z}, 17'h00000, 1'b1, 1'b0},
    // R8: end on empty stack
    '{4'd8, 4'd1, '{T_END, Z, Z, Z, Z, Z, Z, Z, Z, Z, Z, Z}, 17'h00000, 1'b1, 1'b0},
    // R1: unknown operator code
    '{4'd1, 4'd3, '{opd(0,1), T_BAD, T_END, Z, Z, Z, Z, Z, Z, Z, Z, Z}, 17'h00000, 1'b1, 1'b0},
    // R4: 8 - 3 = 5
    '{4'd4, 4'd4, '{opd(0,8), opd(0,3), T_SUB, T_END, Z, Z, Z, Z, Z, Z, Z, Z}, 17'h00005, 1'b0, 1'b0},
    // R4: -2 + 7 = 5
    '{4'd4, 4'd4, '{opd(1,2), opd(0,7), T_ADD, T_END, Z, Z, Z, Z, Z, Z, Z, Z}, 17'h00005, 1'b0, 1'b0}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             tok_valid = 1'b0;
  logic             tok_ready;
  logic             tok_is_op = 1'b0;
  logic [VAL_W-1:0] tok_data = '0;
  logic             res_valid;
  logic [VAL_W-1:0] res_value;
  logic             res_neg;
  logic             err_flag;
  logic             ovf_flag;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  int               seen_done;
  logic [VAL_W-1:0] seen_val;
  logic             seen_neg;

  always #(CLK_PERIOD/2) clk = ~clk;

  rpn_eval #(
    .VAL_W (VAL_W),
    .DEPTH (DEPTH)
  ) u_rpn_eval (
    .clk       (clk),
    .rst       (rst),
    .tok_valid (tok_valid),
    .tok_ready (tok_ready),
    .tok_is_op (tok_is_op),
    .tok_data  (tok_data),
    .res_valid (res_valid),
    .res_value (res_value),
    .res_neg   (res_neg),
    .err_flag  (err_flag),
    .ovf_flag  (ovf_flag)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // R1: tag goes to tok_is_op, payload to tok_data
  task automatic send(input logic [17:0] t);
    @(negedge clk);
    tok_valid = 1'b1;
    tok_is_op = t[17];
    tok_data  = t[16:0];
    while (!tok_ready) @(negedge clk);
    @(negedge clk);
    tok_valid = 1'b0;
  endtask

  task automatic watch_done();
    seen_done = 0;
    seen_val  = '0;
    seen_neg  = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (res_valid) begin
        seen_done++;
        seen_val = res_value;
        seen_neg = res_neg;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R12: reset state
    chk(tok_ready == 1'b1, "R12 ready", 32'(tok_ready), 32'd1);
    chk(res_valid == 1'b0, "R12 done", 32'(res_valid), 32'd0);
    chk(res_value == '0, "R12 value", 32'(res_value), 32'd0);
    chk(res_neg == 1'b0, "R12 neg", 32'(res_neg), 32'd0);
    chk(err_flag == 1'b0, "R12 err", 32'(err_flag), 32'd0);
    chk(ovf_flag == 1'b0, "R12 ovf", 32'(ovf_flag), 32'd0);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      for (int i = 0; i < 15; i++) begin
        if (i < int'(VEC[v].ntk)) send(VEC[v].tk[i]);
      end
      watch_done();
      if (VEC[v].exp_err) begin
        chk(seen_done == 0, $sformatf("R8 no done vec %0d (R%0d)", v, VEC[v].req), 32'(seen_done), 32'd0);
      end else begin
        chk(seen_done == 1, $sformatf("R6 done pulse vec %0d", v), 32'(seen_done), 32'd1);
        chk(seen_val == VEC[v].exp, $sformatf("R%0d value vec %0d", VEC[v].req, v), 32'(seen_val), 32'(VEC[v].exp));
        chk(seen_neg == VEC[v].exp[16], $sformatf("R6 neg vec %0d", v), 32'(seen_neg), 32'(VEC[v].exp[16]));
      end
      chk(err_flag == VEC[v].exp_err, $sformatf("R7/R8 err vec %0d", v), 32'(err_flag), 32'(VEC[v].exp_err));
      chk(ovf_flag == VEC[v].exp_ovf, $sformatf("R10 ovf vec %0d", v), 32'(ovf_flag), 32'(VEC[v].exp_ovf));
    end

    // R2 and R3: handshake timing around an operator
    send(opd(0, 1));
    chk(tok_ready == 1'b1, "R2 ready after value", 32'(tok_ready), 32'd1);
    send(opd(0, 2));
    send(T_ADD);
    chk(tok_ready == 1'b0, "R3 stall cycle 1", 32'(tok_ready), 32'd0);
    @(negedge clk);
    chk(tok_ready == 1'b0, "R3 stall cycle 2", 32'(tok_ready), 32'd0);
    @(negedge clk);
    chk(tok_ready == 1'b1, "R3 ready again", 32'(tok_ready), 32'd1);
    send(T_END);
    chk(res_valid == 1'b0, "R6 not before second edge", 32'(res_valid), 32'd0);
    @(negedge clk);
    chk(res_valid == 1'b1, "R6 done timing", 32'(res_valid), 32'd1);
    chk(res_value == 17'h00003, "R6 value", 32'(res_value), 32'd3);
    @(negedge clk);

    // R11: error persists while idle, clears on next token
    send(T_END);
    repeat (3) @(negedge clk);
    chk(err_flag == 1'b1, "R11 err held", 32'(err_flag), 32'd1);
    send(opd(0, 1));
    chk(err_flag == 1'b0, "R11 err cleared", 32'(err_flag), 32'd0);
    send(T_END);
    watch_done();
    chk(seen_done == 1 && seen_val == 17'h00001, "R11 clean after clear", 32'(seen_val), 32'd1);

    // R9: push onto a full stack
    for (int i = 0; i < DEPTH; i++) send(opd(0, 16'(i % 16)));
    chk(err_flag == 1'b0, "R9 no err at full", 32'(err_flag), 32'd0);
    send(opd(0, 4'hF));
    chk(err_flag == 1'b1, "R9 err on overfill", 32'(err_flag), 32'd1);
    send(T_END);
    watch_done();
    chk(seen_done == 0, "R8 no done after overfill", 32'(seen_done), 32'd0);

    // R11: stack emptied by end, next expression is clean
    send(opd(1, 4'd6));
    send(T_END);
    watch_done();
    chk(seen_done == 1 && seen_val == 17'h10006, "R11 empty after end", 32'(seen_val), 32'h10006);
    chk(res_neg == 1'b1, "R6 neg flag", 32'(res_neg), 32'd1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule